// File: doc/BRIEF.md
# Runahead Mode Checkpoint Controller

This block sits beside the retirement stage of an in-order retirement model and decides when the core stops stalling on a long data-cache miss and starts pre-executing past it. When the instruction at the head of the window is a load that missed, the controller snapshots the architectural registers, the rename map, the return-stack pointer and the global branch history. It then lets younger work run speculatively. During that time it keeps one poison bit per register, so instructions fed by unknown data are not executed and their results are marked unknown.

Runahead work never commits. Its only value is the memory traffic it starts. When the miss data comes back, the controller spends one cycle copying the snapshot back into place and clearing every poison bit. It also presents the saved map, stack pointer, history and the address of the missing load, so that fetch can restart there. The pipeline, the caches and the branch predictor stay outside the block. They talk to it through a head-of-window port, a writeback port and a live-state input bus.

Top module: `rh_ckpt_ctrl`

## Requirements
- R1: The block leaves normal mode only when `head_valid_i`, `head_is_load_i` and `head_miss_i` are all high in normal mode. A hit, or a miss reported for a non-load, leaves it in normal mode. `runahead_o` rises on the edge after a qualifying entry cycle.
- R2: On entry the block saves all registers together with `rmap_i`, `ras_ptr_i`, `ghr_i` and `head_pc_i`. During the restore cycle, `ckpt_rmap_o`, `ckpt_ras_ptr_o`, `ckpt_ghr_o` and `restart_pc_o` carry those saved values.
- R3: After entry, the missing load's destination register reads 0 and its poison flag reads 1.
- R4: `commit_en_o` is high only in normal mode on a cycle that is not an entry cycle.
- R5: In runahead mode, a writeback with any poisoned source gives `exec_en_o`=0. It leaves the destination data unchanged and poisons the destination.
- R6: In runahead mode, a writeback with clean sources gives `exec_en_o`=1. It writes `wb_data_i` and clears the destination's poison flag, unless `wb_miss_i` is high. In that case only the poison flag is set.
- R7: `recover_o` is high only when `wb_is_br_i` and `wb_mispred_i` are high and the instruction executes. A branch with a poisoned source never recovers.
- R8: `miss_ret_i` in runahead mode gives exactly one restore cycle (`restore_o`=1), then normal mode. After it, every register holds its value from the entry cycle and every poison flag is clear, whatever was written in between.
- R9: If `miss_ret_i` is high in the entry cycle, the block goes straight to the restore cycle and `runahead_o` never rises.
- R10: A head-of-window miss seen during runahead mode does not take a new snapshot. `restart_pc_o` keeps its entry value.
- R11: In normal mode, a writeback (`wb_valid_i`) writes its register. During the restore cycle the writeback port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| head_valid_i | input | 1 | Oldest instruction present |
| head_is_load_i | input | 1 | Oldest instruction is a load |
| head_miss_i | input | 1 | Oldest instruction missed the data cache |
| head_pc_i | input | PC_W | Address of the oldest instruction |
| head_dst_i | input | IDX_W | Destination register of the oldest instruction |
| miss_ret_i | input | 1 | Outstanding miss data has returned |
| wb_valid_i | input | 1 | Writeback slot valid |
| wb_dst_i | input | IDX_W | Writeback destination register |
| wb_data_i | input | XLEN | Writeback result |
| wb_src_a_i | input | IDX_W | First source register |
| wb_src_b_i | input | IDX_W | Second source register |
| wb_miss_i | input | 1 | Writeback is a load that missed |
| wb_is_br_i | input | 1 | Writeback is a branch |
| wb_mispred_i | input | 1 | Branch was mispredicted |
| rmap_i | input | NUM_REGS*MAP_W | Live rename map |
| ras_ptr_i | input | RAS_W | Live return-stack pointer |
| ghr_i | input | GHR_W | Live global branch history |
| rd_idx_i | input | IDX_W | Register read index |
| runahead_o | output | 1 | Runahead mode active |
| restore_o | output | 1 | Restore cycle |
| commit_en_o | output | 1 | Architectural commit allowed |
| exec_en_o | output | 1 | Writeback instruction may execute |
| recover_o | output | 1 | Misprediction recovery allowed |
| restart_pc_o | output | PC_W | Fetch restart address |
| ckpt_rmap_o | output | NUM_REGS*MAP_W | Saved rename map |
| ckpt_ras_ptr_o | output | RAS_W | Saved return-stack pointer |
| ckpt_ghr_o | output | GHR_W | Saved branch history |
| rd_data_o | output | XLEN | Register read data |
| rd_inv_o | output | 1 | Poison flag of the read register |

## Verification
The assertions assume the writeback port is sampled against the poison flags as they stand before the edge. They also assume `miss_ret_i` carries meaning only while a miss is outstanding. For that reason the checks on exit timing are tied to the mode outputs and never to the return pulse alone. The stimulus keeps every input a defined value at every cycle and changes inputs only at the falling edge. Random stimulus may raise `miss_ret_i` outside runahead mode, so the blocks that ignore it there are exercised. A separate directed case covers the return arriving in the same cycle as entry.

// File: rtl/rh_pkg.sv
package rh_pkg;
  typedef enum logic [1:0] {
    RH_NORMAL   = 2'd0,
    RH_RUNAHEAD = 2'd1,
    RH_RESTORE  = 2'd2
  } rh_mode_e;
endpackage

// File: rtl/rh_mode_fsm.sv
module rh_mode_fsm import rh_pkg::*; (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     enter_req_i,
  input  logic     miss_ret_i,
  output rh_mode_e mode_o,
  output logic     enter_o
);
  rh_mode_e mode_q, mode_d;

  assign enter_o = enter_req_i && (mode_q == RH_NORMAL);
  assign mode_o  = mode_q;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      RH_NORMAL:   if (enter_o) mode_d = miss_ret_i ? RH_RESTORE : RH_RUNAHEAD;
      RH_RUNAHEAD: if (miss_ret_i) mode_d = RH_RESTORE;
      RH_RESTORE:  mode_d = RH_NORMAL;
      default:     mode_d = RH_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= RH_NORMAL;
    else         mode_q <= mode_d;
  end
endmodule

// File: rtl/rh_reg_ckpt.sv
module rh_reg_ckpt #(
  parameter int NUM_REGS = 8,
  parameter int XLEN     = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [XLEN-1:0]  rd_data_o
);
  logic [XLEN-1:0] live_q [NUM_REGS];
  logic [XLEN-1:0] ck_q   [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[g] <= '0;
        ck_q[g]   <= '0;
      end else begin
        if (save_i) ck_q[g] <= live_q[g];
        if (restore_i)                             live_q[g] <= ck_q[g];
        else if (we_i && widx_i == IDX_W'(g))      live_q[g] <= wdata_i;
      end
    end
  end

  assign rd_data_o = live_q[rd_idx_i];
endmodule

// File: rtl/rh_poison.sv
module rh_poison #(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_all_i,
  input  logic                set_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  input  logic                clr_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  input  logic [IDX_W-1:0]    src_a_i,
  input  logic [IDX_W-1:0]    src_b_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic                src_bad_o,
  output logic                rd_inv_o,
  output logic [NUM_REGS-1:0] inv_o
);
  logic [NUM_REGS-1:0] inv_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  inv_q[g] <= 1'b0;
      else if (clear_all_i)                         inv_q[g] <= 1'b0;
      else if (set_i && set_idx_i == IDX_W'(g))     inv_q[g] <= 1'b1;
      else if (clr_i && clr_idx_i == IDX_W'(g))     inv_q[g] <= 1'b0;
    end
  end

  assign src_bad_o = inv_q[src_a_i] || inv_q[src_b_i];
  assign rd_inv_o  = inv_q[rd_idx_i];
  assign inv_o     = inv_q;
endmodule

// File: rtl/rh_ckpt_ctrl.sv
module rh_ckpt_ctrl import rh_pkg::*; #(
  parameter int NUM_REGS = 8,
  parameter int XLEN     = 16,
  parameter int MAP_W    = 4,
  parameter int RAS_W    = 3,
  parameter int GHR_W    = 8,
  parameter int PC_W     = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int RMAP_W  = NUM_REGS * MAP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_valid_i,
  input  logic              head_is_load_i,
  input  logic              head_miss_i,
  input  logic [PC_W-1:0]   head_pc_i,
  input  logic [IDX_W-1:0]  head_dst_i,
  input  logic              miss_ret_i,
  input  logic              wb_valid_i,
  input  logic [IDX_W-1:0]  wb_dst_i,
  input  logic [XLEN-1:0]   wb_data_i,
  input  logic [IDX_W-1:0]  wb_src_a_i,
  input  logic [IDX_W-1:0]  wb_src_b_i,
  input  logic              wb_miss_i,
  input  logic              wb_is_br_i,
  input  logic              wb_mispred_i,
  input  logic [RMAP_W-1:0] rmap_i,
  input  logic [RAS_W-1:0]  ras_ptr_i,
  input  logic [GHR_W-1:0]  ghr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              runahead_o,
  output logic              restore_o,
  output logic              commit_en_o,
  output logic              exec_en_o,
  output logic              recover_o,
  output logic [PC_W-1:0]   restart_pc_o,
  output logic [RMAP_W-1:0] ckpt_rmap_o,
  output logic [RAS_W-1:0]  ckpt_ras_ptr_o,
  output logic [GHR_W-1:0]  ckpt_ghr_o,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              rd_inv_o
);
  rh_mode_e            mode;
  logic                enter, in_norm, in_ra, in_rs, src_bad;
  logic                rf_we, p_set, p_clr;
  logic [IDX_W-1:0]    rf_widx;
  logic [XLEN-1:0]     rf_wdata;
  logic [NUM_REGS-1:0] inv_q;

  rh_mode_fsm u_fsm (
    .clk_i, .rst_ni,
    .enter_req_i (head_valid_i && head_is_load_i && head_miss_i),
    .miss_ret_i,
    .mode_o      (mode),
    .enter_o     (enter)
  );

  assign in_norm = (mode == RH_NORMAL);
  assign in_ra   = (mode == RH_RUNAHEAD);
  assign in_rs   = (mode == RH_RESTORE);

  assign exec_en_o   = wb_valid_i && !src_bad && (in_ra || (in_norm && !enter));
  assign recover_o   = exec_en_o && wb_is_br_i && wb_mispred_i;
  assign commit_en_o = in_norm && !enter;
  assign runahead_o  = in_ra;
  assign restore_o   = in_rs;

  // entry plants the placeholder in the missing load's destination
  assign rf_we    = enter || (in_norm && wb_valid_i) || (in_ra && exec_en_o && !wb_miss_i);
  assign rf_widx  = enter ? head_dst_i : wb_dst_i;
  assign rf_wdata = enter ? '0 : wb_data_i;
  assign p_set    = enter || (in_ra && wb_valid_i && (src_bad || wb_miss_i));
  assign p_clr    = in_ra && exec_en_o && !wb_miss_i;

  rh_reg_ckpt #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) u_rf (
    .clk_i, .rst_ni,
    .save_i    (enter),
    .restore_i (in_rs),
    .we_i      (rf_we),
    .widx_i    (rf_widx),
    .wdata_i   (rf_wdata),
    .rd_idx_i,
    .rd_data_o
  );

  rh_poison #(.NUM_REGS(NUM_REGS)) u_poison (
    .clk_i, .rst_ni,
    .clear_all_i (in_rs),
    .set_i       (p_set),
    .set_idx_i   (rf_widx),
    .clr_i       (p_clr),
    .clr_idx_i   (wb_dst_i),
    .src_a_i     (wb_src_a_i),
    .src_b_i     (wb_src_b_i),
    .rd_idx_i,
    .src_bad_o   (src_bad),
    .rd_inv_o,
    .inv_o       (inv_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      restart_pc_o   <= '0;
      ckpt_rmap_o    <= '0;
      ckpt_ras_ptr_o <= '0;
      ckpt_ghr_o     <= '0;
    end else if (enter) begin
      restart_pc_o   <= head_pc_i;
      ckpt_rmap_o    <= rmap_i;
      ckpt_ras_ptr_o <= ras_ptr_i;
      ckpt_ghr_o     <= ghr_i;
    end
  end
endmodule

// File: rtl/rh_ckpt_ctrl_chk.sv
module rh_ckpt_ctrl_chk #(
  parameter int NUM_REGS = 8,
  parameter int PC_W     = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                head_valid_i,
  input logic                head_is_load_i,
  input logic                head_miss_i,
  input logic                miss_ret_i,
  input logic                wb_valid_i,
  input logic [IDX_W-1:0]    wb_src_a_i,
  input logic [IDX_W-1:0]    wb_src_b_i,
  input logic                runahead_o,
  input logic                restore_o,
  input logic                commit_en_o,
  input logic                exec_en_o,
  input logic                recover_o,
  input logic [PC_W-1:0]     restart_pc_o,
  input logic [NUM_REGS-1:0] inv_q
);
  p_entry_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(runahead_o) |-> $past(head_valid_i && head_is_load_i && head_miss_i && !miss_ret_i));

  p_no_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runahead_o || restore_o) |-> !commit_en_o);

  p_poison_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && (inv_q[wb_src_a_i] || inv_q[wb_src_b_i])) |-> !exec_en_o);

  p_br_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> exec_en_o);

  p_restore_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> (!restore_o && !runahead_o));

  p_clean_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> (inv_q == '0));

  p_exit_path_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runahead_o && miss_ret_i) |=> restore_o);

  p_fast_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!runahead_o && !restore_o && head_valid_i && head_is_load_i && head_miss_i && miss_ret_i)
      |=> (restore_o && !runahead_o));

  p_hold_pc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runahead_o && !miss_ret_i) |=> $stable(restart_pc_o));
endmodule

bind rh_ckpt_ctrl rh_ckpt_ctrl_chk #(.NUM_REGS(NUM_REGS), .PC_W(PC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .head_valid_i   (head_valid_i),
  .head_is_load_i (head_is_load_i),
  .head_miss_i    (head_miss_i),
  .miss_ret_i     (miss_ret_i),
  .wb_valid_i     (wb_valid_i),
  .wb_src_a_i     (wb_src_a_i),
  .wb_src_b_i     (wb_src_b_i),
  .runahead_o     (runahead_o),
  .restore_o      (restore_o),
  .commit_en_o    (commit_en_o),
  .exec_en_o      (exec_en_o),
  .recover_o      (recover_o),
  .restart_pc_o   (restart_pc_o),
  .inv_q          (inv_q)
);

// File: tb/rh_ckpt_ctrl_tb_top.sv
module rh_ckpt_ctrl_tb_top;
  localparam int NR = 8, XL = 16, MW = 4, RW = 3, GW = 8, PW = 16;
  localparam int IW = 3;

  logic clk = 0, rst_ni = 0;
  always #5 clk = ~clk;

  logic hv, hl, hm, mret, wbv, wmiss, wbr, wmp;
  logic [PW-1:0] hpc;
  logic [IW-1:0] hdst, wd, wa, wb2, rd_idx;
  logic [XL-1:0] wdata;
  logic [NR*MW-1:0] rmap;
  logic [RW-1:0] ras;
  logic [GW-1:0] ghr;

  logic runahead_o, restore_o, commit_en_o, exec_en_o, recover_o, rd_inv_o;
  logic [PW-1:0] restart_pc_o;
  logic [NR*MW-1:0] ckpt_rmap_o;
  logic [RW-1:0] ckpt_ras_ptr_o;
  logic [GW-1:0] ckpt_ghr_o;
  logic [XL-1:0] rd_data_o;

  rh_ckpt_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .head_valid_i(hv), .head_is_load_i(hl), .head_miss_i(hm),
    .head_pc_i(hpc), .head_dst_i(hdst), .miss_ret_i(mret),
    .wb_valid_i(wbv), .wb_dst_i(wd), .wb_data_i(wdata),
    .wb_src_a_i(wa), .wb_src_b_i(wb2), .wb_miss_i(wmiss),
    .wb_is_br_i(wbr), .wb_mispred_i(wmp),
    .rmap_i(rmap), .ras_ptr_i(ras), .ghr_i(ghr), .rd_idx_i(rd_idx),
    .runahead_o, .restore_o, .commit_en_o, .exec_en_o, .recover_o,
    .restart_pc_o, .ckpt_rmap_o, .ckpt_ras_ptr_o, .ckpt_ghr_o,
    .rd_data_o, .rd_inv_o
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model: 0 normal, 1 runahead, 2 restore
  int m_st = 0;
  logic [XL-1:0] m_reg [NR];
  logic          m_inv [NR];
  logic [XL-1:0] ck_reg [NR];
  logic [PW-1:0] ck_pc = '0;
  logic [NR*MW-1:0] ck_rmap = '0;
  logic [RW-1:0] ck_ras = '0;
  logic [GW-1:0] ck_ghr = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    hv = 0; hl = 0; hm = 0; mret = 0; wbv = 0; wmiss = 0; wbr = 0; wmp = 0;
    hpc = '0; hdst = '0; wd = '0; wa = '0; wb2 = '0; wdata = '0;
    rmap = '0; ras = '0; ghr = '0; rd_idx = '0;
  endtask

  function automatic bit exp_exec(bit enter);
    bit ok;
    ok = wbv && !(m_inv[wa] || m_inv[wb2]);
    return ok && ((m_st == 1) || (m_st == 0 && !enter));
  endfunction

  // call after inputs are set at a falling edge; returns after the rising edge
  task automatic tick();
    bit enter, ex, badsrc;
    #1;
    enter = (m_st == 0) && hv && hl && hm;
    ex = exp_exec(enter);
    chk("R1 R9 runahead_o", runahead_o, m_st == 1);
    chk("R8 restore_o", restore_o, m_st == 2);
    chk("R4 commit_en_o", commit_en_o, (m_st == 0) && !enter);
    chk("R5 R6 exec_en_o", exec_en_o, ex);
    chk("R7 recover_o", recover_o, ex && wbr && wmp);
    chk("R6 R11 rd_data_o", rd_data_o, m_reg[rd_idx]);
    chk("R3 rd_inv_o", rd_inv_o, m_inv[rd_idx]);
    if (m_st == 2) begin
      chk("R2 R10 restart_pc_o", restart_pc_o, ck_pc);
      chk("R2 ckpt_rmap_o", ckpt_rmap_o, ck_rmap);
      chk("R2 ckpt_ras_ptr_o", ckpt_ras_ptr_o, ck_ras);
      chk("R2 ckpt_ghr_o", ckpt_ghr_o, ck_ghr);
    end
    badsrc = m_inv[wa] || m_inv[wb2];
    @(posedge clk);
    case (m_st)
      0: if (enter) begin
           for (int i = 0; i < NR; i++) ck_reg[i] = m_reg[i];
           ck_pc = hpc; ck_rmap = rmap; ck_ras = ras; ck_ghr = ghr;
           m_reg[hdst] = '0; m_inv[hdst] = 1;
           m_st = mret ? 2 : 1;
         end else if (wbv) m_reg[wd] = wdata;
      1: begin
           if (wbv) begin
             if (badsrc || wmiss) m_inv[wd] = 1;
             else begin m_reg[wd] = wdata; m_inv[wd] = 0; end
           end
           if (mret) m_st = 2;
         end
      default: begin
           for (int i = 0; i < NR; i++) begin m_reg[i] = ck_reg[i]; m_inv[i] = 0; end
           m_st = 0;
         end
    endcase
  endtask

  task automatic dump_regs();
    for (int i = 0; i < NR; i++) begin
      @(negedge clk); idle(); rd_idx = IW'(i);
      #1;
      chk("R8 reg equals entry snapshot", rd_data_o, ck_reg[i]);
      chk("R8 poison clear", rd_inv_o, 0);
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NR; i++) begin m_reg[i] = '0; m_inv[i] = 0; ck_reg[i] = '0; end
    idle();
    #2;
    chk("R4 reset commit_en_o", commit_en_o, 1);
    chk("R1 reset runahead_o", runahead_o, 0);
    chk("R8 reset restore_o", restore_o, 0);
    chk("R11 reset rd_data_o", rd_data_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R11 preload in normal mode
    for (int i = 0; i < NR; i++) begin
      @(negedge clk); idle(); wbv = 1; wd = IW'(i); wdata = XL'(16'h100 + i * 3); rd_idx = IW'(i);
      tick();
    end
    // R1 negatives: hit load, missing non-load
    @(negedge clk); idle(); hv = 1; hl = 1; hm = 0; tick();
    @(negedge clk); idle(); hv = 1; hl = 0; hm = 1; tick();
    // R1 R2 entry
    @(negedge clk); idle(); hv = 1; hl = 1; hm = 1; hpc = 16'h4242; hdst = 3'd2;
    rmap = 32'hA5A5_1234; ras = 3'd5; ghr = 8'h3c; tick();
    // R3 placeholder
    @(negedge clk); idle(); rd_idx = 3'd2; tick();
    // R5 poisoned source
    @(negedge clk); idle(); wbv = 1; wa = 3'd2; wb2 = 3'd0; wd = 3'd4; wdata = 16'hffff; rd_idx = 3'd4; tick();
    // R6 clean sources
    @(negedge clk); idle(); wbv = 1; wa = 3'd1; wb2 = 3'd3; wd = 3'd5; wdata = 16'h5555; rd_idx = 3'd5; tick();
    // R6 later miss
    @(negedge clk); idle(); wbv = 1; wmiss = 1; wd = 3'd6; wdata = 16'h6666; rd_idx = 3'd6; tick();
    // R7 poisoned branch, then clean branch
    @(negedge clk); idle(); wbv = 1; wbr = 1; wmp = 1; wa = 3'd4; wd = 3'd7; tick();
    @(negedge clk); idle(); wbv = 1; wbr = 1; wmp = 1; wa = 3'd0; wb2 = 3'd1; wd = 3'd7; wdata = 16'h7777; tick();
    // R10 second head miss in runahead
    @(negedge clk); idle(); hv = 1; hl = 1; hm = 1; hpc = 16'h9999; hdst = 3'd1; rmap = 32'h1111_1111; tick();
    // R8 exit, R11 writeback in restore cycle ignored
    @(negedge clk); idle(); mret = 1; tick();
    @(negedge clk); idle(); wbv = 1; wd = 3'd1; wdata = 16'hbeef; tick();
    dump_regs();
    // R9 same-cycle return
    @(negedge clk); idle(); hv = 1; hl = 1; hm = 1; mret = 1; hpc = 16'h0077; hdst = 3'd0; ghr = 8'h81; tick();
    @(negedge clk); idle(); tick();
    dump_regs();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      hv = $urandom_range(0, 1) == 1; hl = $urandom_range(0, 1) == 1;
      hm = $urandom_range(0, 7) == 0;
      hpc = PW'($urandom); hdst = IW'($urandom);
      mret = $urandom_range(0, 15) == 0;
      wbv = $urandom_range(0, 3) != 0; wd = IW'($urandom); wdata = XL'($urandom);
      wa = IW'($urandom); wb2 = IW'($urandom);
      wmiss = $urandom_range(0, 7) == 0; wbr = $urandom_range(0, 1) == 1; wmp = $urandom_range(0, 1) == 1;
      rmap = ($urandom); ras = RW'($urandom); ghr = GW'($urandom); rd_idx = IW'($urandom);
      tick();
    end
    @(negedge clk); idle(); tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule